// File: doc/BRIEF.md
# Cascadable Duty-Cycle Clock Divider Bank

This block holds a row of five post-scale divider stages that all run from one fast reference clock. Each stage makes an output clock whose high phase and low phase last a configured number of input cycles. Their sum sets the division ratio, and one stage can divide by up to 512. A half-period bit lengthens the high phase by half a reference period. An odd ratio can then give an exact 50% duty cycle.

Any stage after the first can take the rising edges of the stage before it as its input cycles instead of the reference clock. A chain of stages then divides by the product of its settings. A bypass bit turns a stage into divide-by-1, so it passes its input clock straight through.

Configuration is static. The block copies it only while reset is held, so changes made while the stages run have no effect. After reset is released, every output starts from a common edge. The intended use is a clock-generation tile, where software or a boot sequence sets the ratios once before the tile is brought out of reset.

Top module: `clkdiv_chain`

## Requirements
- R1: While reset is held high, every bit of `clk_out` is 0, and this includes stages set to bypass.
- R2: A stage that takes the reference clock and is not bypassed gives a period of H+L reference cycles and a high time of H reference cycles. H is read from `cfg_high[8*i +: 8]` and L from `cfg_low[8*i +: 8]` for stage i.
- R3: When `cfg_half[i]` is 1 on a stage fed by the reference clock, the high time becomes H+0.5 reference cycles and the period stays H+L.
- R4: When `cfg_bypass[i]` is 1, the stage's output is its input clock. From the reference clock this is high for one half-cycle with a period of one cycle. In a chain, the output is identical to the preceding stage's output.
- R5: When `cfg_chain[i]` is 1 for a stage i>0, each rising edge of stage i-1 counts as one input cycle. The period is then (H+L)×P and the high time is H×P, where P is the period of stage i-1.
- R6: `cfg_half[i]` has no effect on a stage whose `cfg_chain[i]` is 1.
- R7: `cfg_chain[0]` has no effect, because stage 0 always counts the reference clock.
- R8: A high or low count of 0 stands for 256 input cycles.
- R9: All outputs are low before the first rising reference edge at which reset is sampled low. Every non-bypassed stage fed by the reference clock rises at that edge, so stages with equal settings stay edge-aligned.
- R10: All configuration, including the chain select, is captured only while reset is high. Changing the configuration inputs while the stages run leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock that drives every stage |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while it is high |
| cfg_high | input | 5*8 | High-phase count per stage, stage i in bits [8*i +: 8], 0 means 256 |
| cfg_low | input | 5*8 | Low-phase count per stage, stage i in bits [8*i +: 8], 0 means 256 |
| cfg_half | input | 5 | Per-stage half-period extension of the high phase |
| cfg_bypass | input | 5 | Per-stage divide-by-1 pass-through |
| cfg_chain | input | 5 | Per-stage select of the preceding stage as input (ignored for stage 0) |
| clk_out | output | 5 | Divided clock outputs, bit i from stage i |

## Verification
The assertions rely on two conditions at the inputs. Reset changes at most once per reference cycle, and the configuration inputs settle before reset is dropped. Under these conditions the reset-quiet check and the phase-length bounds see a consistent captured setting.

The stimulus changes every input shortly after a rising reference edge. It holds reset for several cycles around each new setting. It changes configuration during operation only to show that those changes are ignored. The outputs are sampled in the middle of each reference half-cycle, so the half-period extension and the bypassed reference clock read unambiguously.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // width of one phase count; a stage counts 1..2**CW cycles per phase
    localparam int CW = 8;

    // captured per-stage setting
    typedef struct packed {
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
        logic          half;
        logic          bypass;
        logic          cascade;
    } stage_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    // a zero count stands for the full 2**CW
    function automatic logic [CW:0] eff_count(input logic [CW-1:0] c);
        return (c == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, c};
    endfunction

endpackage

// File: rtl/clkdiv_count.sv
module clkdiv_count
    import clkdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] hi,
    input  logic [CW-1:0] lo,
    output logic          q,
    output logic          rise_nxt
);

    phase_e        phase;
    logic [CW:0]   remain;

    // this edge starts a high phase (handed to a chained successor)
    always_comb begin
        rise_nxt = en && ((phase == PH_IDLE) ||
                          ((phase == PH_LOW) && (remain == '0)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            remain <= '0;
        end else if (en) begin
            case (phase)
                PH_IDLE: begin
                    phase  <= PH_HIGH;
                    remain <= eff_count(hi) - 1'b1;
                end
                PH_HIGH: begin
                    if (remain == '0) begin
                        phase  <= PH_LOW;
                        remain <= eff_count(lo) - 1'b1;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (remain == '0) begin
                        phase  <= PH_HIGH;
                        remain <= eff_count(hi) - 1'b1;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                default: begin
                    phase  <= PH_IDLE;
                    remain <= '0;
                end
            endcase
        end
    end

    assign q = (phase == PH_HIGH);

    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HIGH) |-> (remain < eff_count(hi))) else $error("high phase count out of range"); // R2

    AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOW) |-> (remain < eff_count(lo))) else $error("low phase count out of range"); // R8

    AST_RISE_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        rise_nxt |=> q) else $error("announced rising edge missing"); // R5

    AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ($rose(q) || $fell(q)) |-> $past(en)) else $error("output moved without an input cycle"); // R5

endmodule

// File: rtl/clkdiv_shape.sv
module clkdiv_shape (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic in_clk,
    input  logic q_cnt,
    input  logic half_en,
    input  logic bypass,
    output logic out
);

    // copy of the counter output delayed to the falling reference edge
    logic q_neg;

    always_ff @(negedge clk) begin
        if (rst) begin
            q_neg <= 1'b0;
        end else begin
            q_neg <= q_cnt;
        end
    end

    always_comb begin
        if (bypass) begin
            out = in_clk & run;
        end else begin
            out = q_cnt | (half_en & q_neg);
        end
    end

endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
    import clkdiv_pkg::*;
#(
    parameter int NUM_CNT = 5
) (
    input  logic                  clk_ref,
    input  logic                  rst,
    input  logic [NUM_CNT*CW-1:0] cfg_high,
    input  logic [NUM_CNT*CW-1:0] cfg_low,
    input  logic [NUM_CNT-1:0]    cfg_half,
    input  logic [NUM_CNT-1:0]    cfg_bypass,
    input  logic [NUM_CNT-1:0]    cfg_chain,
    output logic [NUM_CNT-1:0]    clk_out
);

    localparam int LAST = NUM_CNT - 1;

    logic               run;
    logic [NUM_CNT-1:0] stg_rise;
    logic [NUM_CNT-1:0] stg_clk;

    always_ff @(posedge clk_ref) begin
        if (rst) begin
            run <= 1'b0;
        end else begin
            run <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_stage
        stage_cfg_t cfg_q;
        logic       tick;
        logic       src_clk;
        logic       cnt_q;
        logic       cnt_rise;
        logic       half_ok;

        // setting is copied only while reset is held
        always_ff @(posedge clk_ref) begin
            if (rst) begin
                cfg_q <= '{hi:      cfg_high[i*CW +: CW],
                           lo:      cfg_low[i*CW +: CW],
                           half:    cfg_half[i],
                           bypass:  cfg_bypass[i],
                           cascade: cfg_chain[i] && (i != 0)};
            end
        end

        if (i == 0) begin : g_head
            assign tick    = ~rst;
            assign src_clk = clk_ref;
        end else begin : g_link
            assign tick    = cfg_q.cascade ? stg_rise[i-1] : ~rst;
            assign src_clk = cfg_q.cascade ? stg_clk[i-1]  : clk_ref;
        end

        // half-period shaping only makes sense on the reference clock
        assign half_ok = cfg_q.half & ~cfg_q.cascade;

        clkdiv_count u_count (
            .clk      (clk_ref),
            .rst      (rst),
            .en       (tick),
            .hi       (cfg_q.hi),
            .lo       (cfg_q.lo),
            .q        (cnt_q),
            .rise_nxt (cnt_rise)
        );

        clkdiv_shape u_shape (
            .clk     (clk_ref),
            .rst     (rst),
            .run     (run),
            .in_clk  (src_clk),
            .q_cnt   (cnt_q),
            .half_en (half_ok),
            .bypass  (cfg_q.bypass),
            .out     (stg_clk[i])
        );

        assign stg_rise[i] = cfg_q.bypass ? tick : cnt_rise;
    end

    assign clk_out = stg_clk;

    AST_RESET_QUIET: assert property (@(posedge clk_ref)
        (rst && $past(rst)) |-> (stg_clk == '0)) else $error("output active during reset"); // R1

    AST_LAST_STAGE_IDLE: assert property (@(posedge clk_ref)
        (rst && $past(rst)) |-> !stg_rise[LAST]) else $error("rising edge announced during reset"); // R9

endmodule

// File: tb/clkdiv_chain_tb.sv
module clkdiv_chain_tb;
    import clkdiv_pkg::*;

    localparam int N = 5;

    logic             clk_ref = 1'b0;
    logic             rst     = 1'b1;
    logic [N*CW-1:0]  cfg_high   = '0;
    logic [N*CW-1:0]  cfg_low    = '0;
    logic [N-1:0]     cfg_half   = '0;
    logic [N-1:0]     cfg_bypass = '0;
    logic [N-1:0]     cfg_chain  = '0;
    logic [N-1:0]     clk_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    idx;
        int    period;
        int    high;
        string req;
    } exp_t;

    exp_t sb_q[$];

    clkdiv_chain #(.NUM_CNT(N)) u_dut (
        .clk_ref    (clk_ref),
        .rst        (rst),
        .cfg_high   (cfg_high),
        .cfg_low    (cfg_low),
        .cfg_half   (cfg_half),
        .cfg_bypass (cfg_bypass),
        .cfg_chain  (cfg_chain),
        .clk_out    (clk_out)
    );

    always #5 clk_ref = ~clk_ref;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic set_stage(input int i, input int hi, input int lo,
                             input bit half, input bit byp, input bit chain);
        cfg_high[i*CW +: CW] = CW'(hi);
        cfg_low[i*CW +: CW]  = CW'(lo);
        cfg_half[i]   = half;
        cfg_bypass[i] = byp;
        cfg_chain[i]  = chain;
    endtask

    // driver side of the scoreboard; period and high in half-cycles
    task automatic push_exp(input int idx, input int period, input int high, input string req);
        exp_t e;
        e.idx = idx; e.period = period; e.high = high; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic half_step();
        @(clk_ref);
        #2.5;
    endtask

    task automatic measure(input int idx, output int per, output int hi);
        int   guard = 0;
        logic prev;
        logic cur;
        bit   in_high;
        bit   found = 0;
        per = -1;
        hi  = -1;
        half_step();
        prev = clk_out[idx];
        while (guard < 8000) begin
            half_step();
            guard++;
            cur = clk_out[idx];
            if (!prev && cur) begin
                found = 1;
                break;
            end
            prev = cur;
        end
        if (found) begin
            per = 1; hi = 1; in_high = 1;
            while (guard < 8000) begin
                half_step();
                guard++;
                cur = clk_out[idx];
                if (cur && in_high) begin
                    hi++; per++;
                end else if (!cur) begin
                    in_high = 0; per++;
                end else begin
                    break;
                end
            end
        end
    endtask

    // monitor side: pop each expectation and compare against the output
    task automatic drain();
        exp_t e;
        int   p;
        int   h;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            measure(e.idx, p, h);
            check(p == e.period, e.req, $sformatf("stage %0d period", e.idx), p, e.period);
            check(h == e.high,   e.req, $sformatf("stage %0d high", e.idx),   h, e.high);
        end
    endtask

    // hold reset, check quiet outputs (R1), release after a rising edge
    task automatic reset_phase();
        @(posedge clk_ref);
        #1 rst = 1'b1;
        repeat (3) @(posedge clk_ref);
        for (int k = 0; k < 4; k++) begin
            half_step();
            check(clk_out == '0, "R1", "outputs in reset", int'(clk_out), 0);
        end
        @(posedge clk_ref);
        #1 rst = 1'b0;
    endtask

    initial begin
        // ---- setting A: basic ratios, half, bypass, chaining, ignored bits
        set_stage(0, 3, 2, 1'b0, 1'b0, 1'b1);   // R7: chain on stage 0 ignored
        set_stage(1, 2, 3, 1'b1, 1'b0, 1'b0);   // R3
        set_stage(2, 1, 1, 1'b0, 1'b1, 1'b0);   // R4 bypass of reference
        set_stage(3, 4, 4, 1'b0, 1'b0, 1'b1);   // R5 chained to bypass
        set_stage(4, 1, 1, 1'b1, 1'b0, 1'b1);   // R5 and R6
        reset_phase();
        push_exp(0, 10, 6,  "R2/R7");
        push_exp(1, 10, 5,  "R3");
        push_exp(2, 2,  1,  "R4");
        push_exp(3, 16, 8,  "R5");
        push_exp(4, 32, 16, "R6");
        drain();

        // ---- setting B: start alignment, zero count, chained bypass
        set_stage(0, 4, 4, 1'b0, 1'b0, 1'b0);
        set_stage(1, 4, 4, 1'b0, 1'b0, 1'b0);
        set_stage(2, 0, 1, 1'b0, 1'b0, 1'b0);   // R8: 256 + 1
        set_stage(3, 2, 2, 1'b0, 1'b0, 1'b1);
        set_stage(4, 5, 5, 1'b0, 1'b1, 1'b1);   // R4 chained bypass
        reset_phase();
        half_step();
        check(clk_out == '0, "R9", "outputs before first edge", int'(clk_out), 0);
        half_step();
        check(clk_out == 5'b11111, "R9", "outputs after first edge", int'(clk_out), 31);
        for (int k = 0; k < 40; k++) begin
            half_step();
            check(clk_out[0] == clk_out[1], "R9", "equal stages aligned",
                  int'(clk_out[1]), int'(clk_out[0]));
        end
        push_exp(0, 16,   8,    "R2");
        push_exp(2, 514,  512,  "R8");
        push_exp(3, 2056, 1028, "R5");
        push_exp(4, 2056, 1028, "R4");
        drain();

        // ---- setting C: chain after a half-extended stage, then live changes
        set_stage(0, 3, 4, 1'b1, 1'b0, 1'b0);
        set_stage(1, 1, 2, 1'b0, 1'b0, 1'b1);
        set_stage(2, 1, 1, 1'b0, 1'b0, 1'b0);
        set_stage(3, 1, 1, 1'b0, 1'b0, 1'b0);
        set_stage(4, 1, 1, 1'b0, 1'b0, 1'b0);
        reset_phase();
        push_exp(0, 14, 7,  "R3");
        push_exp(1, 42, 14, "R5");
        drain();
        @(posedge clk_ref);
        #1;
        set_stage(1, 5, 1, 1'b1, 1'b1, 1'b0);   // R10: all ignored while running
        set_stage(0, 2, 2, 1'b0, 1'b0, 1'b0);
        cfg_chain = '0;
        push_exp(1, 42, 14, "R10");
        push_exp(0, 14, 7,  "R10");
        push_exp(2, 4,  2,  "R10");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule